// File: doc/BRIEF.md
# Phase-Reversal Keyer with Amplitude Ramp

This block turns a serial stream of already-encoded symbol bits into an 8-bit unsigned carrier sample stream for a parallel DAC. Each bit occupies a fixed period of `2 * 32 * STEP_SAMPLES` samples. A one bit keeps the carrier at full amplitude and holds its phase. A zero bit fades the carrier down through 32 gain levels to silence during the first half of the period. The carrier phase flips by 180 degrees at the null. The carrier then fades back up to full amplitude during the second half. This keeps the spectrum narrow, where an abrupt phase jump would spread it.

The carrier is an 8-sample sine cycle taken from a small constant table. The gain follows a quarter-sine curve over 32 levels. A new sample is produced every `SAMPLE_DIV` clock cycles and is marked by a one-cycle `sample_valid` pulse.

The output stream has no ready signal, so the DAC side must take every sample in the cycle it is flagged. On the input side, `bit_ready` is a one-cycle request raised only at bit boundaries. A bit transfers when `bit_valid` and `bit_ready` are both high. The source may hold its next bit valid for any length of time, and the block looks at it only during the request cycle. If no valid bit is offered at a boundary, the block treats the bit as a one.

Top module: `psk_keyer`

## Requirements
- R1: While `rst` (active high, synchronous) is high, `sample_data` is 127 and both `sample_valid` and `bit_ready` are 0. After reset the carrier phase is 0, so a one bit ends its period with the value 37.
- R2: `sample_valid` is a one-cycle pulse every `SAMPLE_DIV` cycles. The first pulse comes `SAMPLE_DIV` rising edges after reset is released. `sample_data` changes only together with a pulse.
- R3: `bit_ready` pulses for one cycle, exactly one cycle before the first sample of each bit period. The first pulse comes `SAMPLE_DIV-1` edges after reset. A bit is taken only in that cycle, and it governs the whole period that starts with the next sample.
- R4: Until the first valid bit has been accepted, every sample is 127 (gain level 0). Boundaries without a valid bit do not change this.
- R5: A one bit, or a boundary with no valid bit once running, uses gain level 31 for the whole period and leaves the phase unchanged.
- R6: In a zero bit, ramp step s (s = sample-in-period / `STEP_SAMPLES`, 0..63) uses level 31-s for s<32 and level s-32 for s>=32. The phase is inverted from step 32 onward and stays inverted after the bit.
- R7: The carrier index is (n + 4*phase) mod 8, where n counts samples since reset. The carrier value is C[i] = round(127*sin(2*pi*i/8)).
- R8: The gain at level k is G[k] = round(256*sin(k*pi/64)), so level 0 is silent and level 31 is 256.
- R9: Each sample equals 127 + floor(C*G/256), which stays within 0..254.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_valid | input | 1 | Source offers a bit |
| bit_data | input | 1 | Offered bit value |
| bit_ready | output | 1 | One-cycle bit request at a bit boundary |
| sample_valid | output | 1 | One-cycle strobe marking a new sample |
| sample_data | output | 8 | Unsigned carrier sample, 127 is zero level |

## Verification
A bit accepted in a `bit_ready` cycle appears in the sample registered at the next rising edge, so `sample_valid` for that first sample is high one cycle after the request. Every later sample follows `SAMPLE_DIV` cycles after the previous one. The phase outcome of a bit is visible in the last sample of its period, which arrives `SAMPLE_DIV` cycles before the next request. The bench therefore reads each period's last sample when it sees the following request. It samples all outputs on falling edges or 1 ns after a rising edge. It predicts every sample from its own sample count, the accepted bits and the formulas of R6 to R9.

// File: rtl/psk_pkg.sv
package psk_pkg;
  localparam int LEVELS  = 32;
  localparam int LVL_W   = 5;
  localparam int STEP_W  = LVL_W + 1;
  localparam int CAR_W   = 3;
  localparam int GAIN_W  = 9;

  // one carrier cycle of eight points, scaled by 127
  function automatic logic signed [7:0] carrier_val(input logic [CAR_W-1:0] idx);
    case (idx)
      3'd0: carrier_val = 8'sd0;
      3'd1: carrier_val = 8'sd90;
      3'd2: carrier_val = 8'sd127;
      3'd3: carrier_val = 8'sd90;
      3'd4: carrier_val = 8'sd0;
      3'd5: carrier_val = -8'sd90;
      3'd6: carrier_val = -8'sd127;
      default: carrier_val = -8'sd90;
    endcase
  endfunction

  // quarter-sine gain curve, 256 = unity
  function automatic logic [GAIN_W-1:0] gain_val(input logic [LVL_W-1:0] lvl);
    case (lvl)
      5'd0:  gain_val = 9'd0;
      5'd1:  gain_val = 9'd13;
      5'd2:  gain_val = 9'd25;
      5'd3:  gain_val = 9'd38;
      5'd4:  gain_val = 9'd50;
      5'd5:  gain_val = 9'd62;
      5'd6:  gain_val = 9'd74;
      5'd7:  gain_val = 9'd86;
      5'd8:  gain_val = 9'd98;
      5'd9:  gain_val = 9'd109;
      5'd10: gain_val = 9'd121;
      5'd11: gain_val = 9'd132;
      5'd12: gain_val = 9'd142;
      5'd13: gain_val = 9'd152;
      5'd14: gain_val = 9'd162;
      5'd15: gain_val = 9'd172;
      5'd16: gain_val = 9'd181;
      5'd17: gain_val = 9'd190;
      5'd18: gain_val = 9'd198;
      5'd19: gain_val = 9'd206;
      5'd20: gain_val = 9'd213;
      5'd21: gain_val = 9'd220;
      5'd22: gain_val = 9'd226;
      5'd23: gain_val = 9'd231;
      5'd24: gain_val = 9'd237;
      5'd25: gain_val = 9'd241;
      5'd26: gain_val = 9'd245;
      5'd27: gain_val = 9'd248;
      5'd28: gain_val = 9'd251;
      5'd29: gain_val = 9'd253;
      5'd30: gain_val = 9'd255;
      default: gain_val = 9'd256;
    endcase
  endfunction
endpackage

// File: rtl/psk_timer.sv
module psk_timer
  import psk_pkg::*;
#(
  parameter int SAMPLE_DIV   = 4,
  parameter int STEP_SAMPLES = 256
) (
  input  logic              clk,
  input  logic              rst,
  output logic              tick,
  output logic              first,
  output logic              last,
  output logic [STEP_W-1:0] step,
  output logic [CAR_W-1:0]  car
);
  localparam int DIV_W = (SAMPLE_DIV > 1) ? $clog2(SAMPLE_DIV) : 1;

  logic [DIV_W-1:0]  div_q;
  logic [STEP_W-1:0] step_q;
  logic [CAR_W-1:0]  car_q;
  logic              step_end;
  logic              step_start;

  assign tick = (div_q == DIV_W'(SAMPLE_DIV - 1));

  generate
    if (STEP_SAMPLES == 1) begin : g_single
      assign step_end   = 1'b1;
      assign step_start = 1'b1;
    end else begin : g_multi
      localparam int SUB_W = $clog2(STEP_SAMPLES);
      logic [SUB_W-1:0] sub_q;
      assign step_end   = (sub_q == SUB_W'(STEP_SAMPLES - 1));
      assign step_start = (sub_q == '0);
      always_ff @(posedge clk) begin
        if (rst) begin
          sub_q <= '0;
        end else if (tick) begin
          sub_q <= step_end ? '0 : sub_q + 1'b1;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q  <= '0;
      step_q <= '0;
      car_q  <= '0;
    end else begin
      div_q <= tick ? '0 : div_q + 1'b1;
      if (tick) begin
        car_q <= car_q + 1'b1;
        if (step_end) step_q <= step_q + 1'b1;
      end
    end
  end

  assign first = step_start && (step_q == '0);
  assign last  = step_end && (step_q == '1);
  assign step  = step_q;
  assign car   = car_q;
endmodule

// File: rtl/psk_ramp.sv
module psk_ramp
  import psk_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              first,
  input  logic              last,
  input  logic [STEP_W-1:0] step,
  input  logic              bit_valid,
  input  logic              bit_data,
  output logic [LVL_W-1:0]  level,
  output logic              flip
);
  logic started_q, cur_bit_q, phase_q;
  logic bit_use, run_use, is_zero, second_half;

  // a boundary without an offered bit counts as a steady one
  assign bit_use     = first ? (bit_valid ? bit_data : 1'b1) : cur_bit_q;
  assign run_use     = first ? (started_q | bit_valid) : started_q;
  assign is_zero     = run_use & ~bit_use;
  assign second_half = step[STEP_W-1];
  assign flip        = phase_q ^ (is_zero & second_half);

  always_comb begin
    if (is_zero) begin
      level = second_half ? step[LVL_W-1:0] : ~step[LVL_W-1:0];
    end else if (run_use) begin
      level = LVL_W'(LEVELS - 1);
    end else begin
      level = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      started_q <= 1'b0;
      cur_bit_q <= 1'b1;
      phase_q   <= 1'b0;
    end else if (tick) begin
      started_q <= run_use;
      cur_bit_q <= bit_use;
      if (last) phase_q <= flip;
    end
  end
endmodule

// File: rtl/psk_gen.sv
module psk_gen
  import psk_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [CAR_W-1:0] car,
  input  logic             flip,
  input  logic [LVL_W-1:0] level,
  output logic             sample_valid,
  output logic [7:0]       sample_data
);
  localparam int PROD_W = 8 + GAIN_W + 1;

  logic [CAR_W-1:0]        idx;
  logic signed [7:0]       cval;
  logic signed [GAIN_W:0]  gval;
  logic signed [PROD_W-1:0] prod;
  logic signed [9:0]       sum;

  assign idx  = car + {flip, 2'b00};
  assign cval = carrier_val(idx);
  assign gval = $signed({1'b0, gain_val(level)});
  assign prod = PROD_W'(cval) * PROD_W'(gval);
  assign sum  = $signed(prod[PROD_W-1:8]) + 10'sd127;

  always_ff @(posedge clk) begin
    if (rst) begin
      sample_valid <= 1'b0;
      sample_data  <= 8'd127;
    end else begin
      sample_valid <= tick;
      if (tick) sample_data <= sum[7:0];
    end
  end
endmodule

// File: rtl/psk_keyer.sv
module psk_keyer
  import psk_pkg::*;
#(
  parameter int SAMPLE_DIV   = 4,
  parameter int STEP_SAMPLES = 256
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_valid,
  input  logic       bit_data,
  output logic       bit_ready,
  output logic       sample_valid,
  output logic [7:0] sample_data
);
  logic              tick, first, last, flip;
  logic [STEP_W-1:0] step;
  logic [CAR_W-1:0]  car;
  logic [LVL_W-1:0]  level;

  psk_timer #(.SAMPLE_DIV(SAMPLE_DIV), .STEP_SAMPLES(STEP_SAMPLES)) u_timer (
    .clk(clk), .rst(rst), .tick(tick), .first(first), .last(last),
    .step(step), .car(car)
  );

  psk_ramp u_ramp (
    .clk(clk), .rst(rst), .tick(tick), .first(first), .last(last),
    .step(step), .bit_valid(bit_valid), .bit_data(bit_data),
    .level(level), .flip(flip)
  );

  psk_gen u_gen (
    .clk(clk), .rst(rst), .tick(tick), .car(car), .flip(flip),
    .level(level), .sample_valid(sample_valid), .sample_data(sample_data)
  );

  assign bit_ready = tick & first;
endmodule

// File: rtl/psk_keyer_chk.sv
module psk_keyer_chk #(
  parameter int SAMPLE_DIV = 4
) (
  input logic       clk,
  input logic       rst,
  input logic       bit_valid,
  input logic       bit_ready,
  input logic       sample_valid,
  input logic [7:0] sample_data
);
  logic        seen_bit;
  logic        seen_sample;
  logic [15:0] gap;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_bit    <= 1'b0;
      seen_sample <= 1'b0;
      gap         <= '0;
    end else begin
      if (bit_ready && bit_valid) seen_bit <= 1'b1;
      if (sample_valid) begin
        seen_sample <= 1'b1;
        gap         <= '0;
      end else begin
        gap <= gap + 1'b1;
      end
    end
  end

  assert_reset_out_R1: assert property (@(posedge clk)
    rst |=> (sample_data == 8'd127 && !sample_valid && !bit_ready));

  assert_valid_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    sample_valid |=> !sample_valid);

  assert_sample_gap_R2: assert property (@(posedge clk) disable iff (rst)
    (sample_valid && seen_sample) |-> (gap == 16'(SAMPLE_DIV - 1)));

  assert_data_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !sample_valid |-> $stable(sample_data));

  assert_ready_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    bit_ready |=> !bit_ready);

  assert_ready_sample_R3: assert property (@(posedge clk) disable iff (rst)
    bit_ready |=> sample_valid);

  assert_silent_start_R4: assert property (@(posedge clk) disable iff (rst)
    (!seen_bit && sample_valid) |-> (sample_data == 8'd127));
endmodule

bind psk_keyer psk_keyer_chk #(.SAMPLE_DIV(SAMPLE_DIV)) u_chk (
  .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_ready(bit_ready),
  .sample_valid(sample_valid), .sample_data(sample_data)
);

// File: tb/sim_psk_keyer.sv
module sim_psk_keyer;
  localparam int DIV   = 3;
  localparam int STEP  = 2;
  localparam int LEV   = 32;
  localparam int BITS  = 2 * LEV * STEP;
  localparam int NV    = 12;
  localparam real PI   = 3.14159265358979;

  // {bit_valid, bit_data, expected last sample of that bit period}
  localparam logic [9:0] VEC [0:NV-1] = '{
    {2'b00, 8'd127}, {2'b00, 8'd127}, {2'b11, 8'd37},  {2'b10, 8'd217},
    {2'b10, 8'd37},  {2'b11, 8'd37},  {2'b00, 8'd37},  {2'b10, 8'd217},
    {2'b11, 8'd217}, {2'b10, 8'd37},  {2'b10, 8'd217}, {2'b11, 8'd217}
  };

  logic       clk, rst, bit_valid, bit_data;
  logic       bit_ready, sample_valid;
  logic [7:0] sample_data;

  int nchecks = 0;
  int nerr    = 0;
  int n, last_val;
  bit m_started, m_bit, m_phase, pend, pend_v, pend_d;

  psk_keyer #(.SAMPLE_DIV(DIV), .STEP_SAMPLES(STEP)) u0 (
    .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_data(bit_data),
    .bit_ready(bit_ready), .sample_valid(sample_valid), .sample_data(sample_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchecks++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rnd(input real x);
    return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
  endfunction

  function automatic int c_ref(input int i);
    return rnd(127.0 * $sin(2.0 * PI * i / 8.0));
  endfunction

  function automatic int g_ref(input int k);
    return rnd(256.0 * $sin(k * PI / 64.0));
  endfunction

  function automatic int floor256(input int p);
    return (p >= 0) ? p / 256 : -((-p + 255) / 256);
  endfunction

  // reference model driven only by the port activity
  always @(negedge clk) begin
    if (rst) begin
      n = 0; m_started = 0; m_bit = 1; m_phase = 0; pend = 0;
    end else begin
      if (bit_ready) begin
        check((n % BITS) == 0, "R3 request position", n % BITS, 0);
        pend = 1; pend_v = bit_valid; pend_d = bit_data;
      end
      if (sample_valid) begin
        int q, s, lvl, expv, req_lvl;
        bit zero, ph;
        q = n % BITS;
        s = q / STEP;
        if (q == 0) begin
          check(pend, "R3 request before period", 0, 1);
          m_bit = pend_v ? pend_d : 1'b1;
          m_started = m_started | pend_v;
          pend = 0;
        end
        zero = m_started && !m_bit;
        ph   = m_phase ^ (zero && s >= LEV);
        if (zero) lvl = (s < LEV) ? (LEV - 1 - s) : (s - LEV);
        else      lvl = m_started ? LEV - 1 : 0;
        req_lvl = lvl;
        expv = 127 + floor256(c_ref((n + (ph ? 4 : 0)) % 8) * g_ref(req_lvl));
        if (!m_started)
          check(sample_data == expv, "R4 silent before start", sample_data, expv);
        else if (zero)
          check(sample_data == expv, "R6 R7 R8 R9 zero-bit sample", sample_data, expv);
        else
          check(sample_data == expv, "R5 R7 R8 R9 one-bit sample", sample_data, expv);
        if (q == BITS - 1) begin
          last_val = sample_data;
          if (zero) m_phase = ~m_phase;
        end
        n++;
      end
    end
  end

  task automatic wait_ready();
    do @(negedge clk); while (!bit_ready);
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
  endtask

  initial begin
    #400000;
    nchecks++; nerr++;
    $display("FAIL R3 watchdog actual=hung expected=done");
    report();
    $finish;
  end

  initial begin
    rst = 1'b1; bit_valid = 1'b0; bit_data = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check(sample_data == 8'd127, "R1 reset data", sample_data, 127);
    check(!sample_valid, "R1 reset valid", sample_valid, 0);
    check(!bit_ready, "R1 reset request", bit_ready, 0);
    rst = 1'b0;

    // first request and first sample timing after release
    for (int k = 1; k <= DIV; k++) begin
      @(posedge clk); #1;
      if (k == DIV - 1) begin
        check(bit_ready, "R3 first request timing", bit_ready, 1);
        check(!sample_valid, "R2 no sample yet", sample_valid, 0);
      end else if (k == DIV) begin
        check(sample_valid, "R2 first sample timing", sample_valid, 1);
        check(!bit_ready, "R3 request is one cycle", bit_ready, 0);
      end else begin
        check(!bit_ready, "R3 early request", bit_ready, 0);
      end
    end

    // vector walk: each entry covers one bit period
    for (int i = 0; i < NV; i++) begin
      bit_valid = VEC[i][9];
      bit_data  = VEC[i][8];
      wait_ready();
      if (i > 0)
        check(last_val == int'(VEC[i-1][7:0]), "R5 R6 period end phase",
              last_val, int'(VEC[i-1][7:0]));
      @(posedge clk); #1;
      bit_valid = 1'b0;
    end
    wait_ready();
    check(last_val == int'(VEC[NV-1][7:0]), "R5 R6 period end phase",
          last_val, int'(VEC[NV-1][7:0]));

    // mid-period reset while phase is inverted
    @(posedge clk); #1;
    bit_valid = 1'b1; bit_data = 1'b0;
    repeat (20) @(posedge clk);
    #1 rst = 1'b1;
    @(posedge clk); #1;
    check(sample_data == 8'd127, "R1 mid reset data", sample_data, 127);
    check(!sample_valid && !bit_ready, "R1 mid reset strobes",
          {sample_valid, bit_ready}, 0);
    bit_data = 1'b1;
    @(posedge clk); #1;
    rst = 1'b0;
    wait_ready();
    @(posedge clk); #1;
    bit_valid = 1'b0;
    wait_ready();
    check(last_val == 37, "R1 phase zero after reset", last_val, 37);

    report();
    $finish;
  end
endmodule